// File: doc/BRIEF.md
# Resonant-Model Current Regulator

This block is the digital inner current regulator of a single-phase active rectifier. At each sample it receives a sinusoidal current reference and a measured inductor current, both marked by one sample strobe. From these it forms the tracking error. It advances two internal resonant states that together carry a second-order model of the line frequency. It then issues a converter voltage command. Because the resonator is tuned to the line frequency, the closed loop follows a sinusoidal reference at that frequency with no steady-state error. Harmonics of the reference or of the supply are not compensated and leave a residual error.

All signals are signed two's-complement integers in one data format. The three feedback gains and the resonance coefficient (twice the cosine of the line angle per sample) are signed fixed-point numbers with `COEF_FRAC` fractional bits. They are applied at run time through input ports. Products are scaled back by an arithmetic right shift, which rounds toward minus infinity. The states and the command saturate instead of wrapping. The command is then clamped to programmable limits.

Top module: `resonant_current_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both resonant states, `u_cmd` and `u_valid` are cleared to zero.
- R2: A sample accepted at clock edge N (`smp_valid` high, `clr` low) produces a one-cycle `u_valid` pulse after edge N+2. A new sample may be accepted at every edge, and each accepted sample yields exactly one pulse.
- R3: The command is u = s2 − floor(k3·x / 2^COEF_FRAC), where x is the measured current. It uses the value of state s2 from before the update caused by the same sample.
- R4: The error is e = r − x, where r is the reference. The first state updates as s1' = −s2 − floor(k1·e / 2^COEF_FRAC). Both states hold their values when no sample is processed.
- R5: The second state updates as s2' = s1 + floor(c·s2 / 2^COEF_FRAC) − floor(k2·e / 2^COEF_FRAC), where c is the resonance coefficient.
- R6: s1', s2' and the unclamped command saturate to the signed `DATA_W`-bit range [−2^(DATA_W−1), 2^(DATA_W−1)−1] and never wrap.
- R7: The saturated command is limited first to at most `u_max` and then to at least `u_min`, so `u_min` wins if the limits are inverted.
- R8: `clr` high at an edge zeroes both states. It also discards any sample captured at that edge or in flight, so no `u_valid` pulse results.
- R9: The gains, resonance coefficient and limits are captured together with the sample at its strobe edge. A change on those ports after that edge does not affect that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Zero the resonant states and drop in-flight samples |
| smp_valid | input | 1 | Sample strobe for `i_ref` and `i_meas` |
| i_ref | input | DATA_W | Current reference, signed |
| i_meas | input | DATA_W | Measured inductor current, signed |
| k1_coef | input | COEF_W | Error gain into the first state, signed fixed point |
| k2_coef | input | COEF_W | Error gain into the second state, signed fixed point |
| k3_coef | input | COEF_W | Current feedback gain, signed fixed point |
| res_coef | input | COEF_W | Resonance coefficient 2·cos(ω0·Ts), signed fixed point |
| u_min | input | DATA_W | Lower command limit, signed |
| u_max | input | DATA_W | Upper command limit, signed |
| u_cmd | output | DATA_W | Converter voltage command, signed |
| u_valid | output | 1 | One-cycle pulse marking a new `u_cmd` |

## Verification
The two resonant states cannot be read from the ports. Saturation inside them shows up only indirectly, through the commands of later samples. The stimulus therefore first loads an oversized gain, so that one large error drives the states to their rails. It then restores normal gains and issues more samples, whose commands expose the saturated state values. Cancelling an in-flight sample with `clr` needs a strobe followed one cycle later by a clear pulse. The bench then watches for an unexpected pulse and checks that the next command is computed from zeroed states.

// File: rtl/rcc_pkg.sv
// Package: default number formats shared by the current regulator and its bench.
// Assumes coefficients carry COEF_FRAC fractional bits and data are plain integers.
package rcc_pkg;
    localparam int DATA_W_DEF    = 16;
    localparam int COEF_W_DEF    = 18;
    localparam int COEF_FRAC_DEF = 14;
    localparam int N_MUL         = 4;   // k1*e, k2*e, k3*x, c*s2
    localparam int N_SAT         = 3;   // command, next s1, next s2
endpackage

// File: rtl/rcc_mul.sv
// Module: signed data by fixed-point coefficient product, rescaled by an
// arithmetic right shift of CF bits (rounds toward minus infinity).
// Assumes both operands are two's complement; the output is full width.
module rcc_mul #(
    parameter int AW = 17,
    parameter int CW = 18,
    parameter int CF = 14
) (
    input  logic signed [AW-1:0]    a,
    input  logic signed [CW-1:0]    c,
    output logic signed [AW+CW-1:0] p
);
    localparam int PW = AW + CW;
    logic signed [PW-1:0] full;

    // Exact product, then drop the fractional bits of the coefficient.
    always_comb begin
        full = PW'(a) * PW'(c);
        p    = full >>> CF;
    end
endmodule

// File: rtl/rcc_sat.sv
// Module: saturates a wide signed value into a narrower signed range.
// Assumes IW > OW.
module rcc_sat #(
    parameter int IW = 37,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    // Clip to the output rails, otherwise pass the low bits through.
    always_comb begin
        if (din > HI)      dout = HI[OW-1:0];
        else if (din < LO) dout = LO[OW-1:0];
        else               dout = din[OW-1:0];
    end
endmodule

// File: rtl/rcc_clamp.sv
// Module: limits a signed value to [lo, hi]; the lower limit is applied last
// so it wins when the limits are inverted.
module rcc_clamp #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] din,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] capped;

    // Upper limit first, then lower limit.
    always_comb begin
        capped = (din > hi) ? hi : din;
        dout   = (capped < lo) ? lo : capped;
    end
endmodule

// File: rtl/rcc_state.sv
// Module: the two resonant state registers of the internal model.
// Assumes next values arrive already saturated; upd is a single-cycle enable.
module rcc_state #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                upd,
    input  logic signed [W-1:0] nxt1,
    input  logic signed [W-1:0] nxt2,
    output logic signed [W-1:0] s1,
    output logic signed [W-1:0] s2
);
    // State update: reset and clear zero, otherwise load on upd.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s1 <= '0;
            s2 <= '0;
        end else if (upd) begin
            s1 <= nxt1;
            s2 <= nxt2;
        end
    end

    // R8: a clear leaves both states at zero.
    p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s1 == '0) && (s2 == '0));

    // R4: states hold when no sample is processed.
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(s1) && $stable(s2));
endmodule

// File: rtl/resonant_current_ctrl.sv
// Module: sinusoidal current regulator with a second-order resonant internal
// model inside a state-feedback law. Edge N captures a sample and its
// coefficients; edge N+1 computes the command and advances the states.
// Assumes coefficients are signed fixed point with COEF_FRAC fraction bits.
module resonant_current_ctrl #(
    parameter int DATA_W    = rcc_pkg::DATA_W_DEF,
    parameter int COEF_W    = rcc_pkg::COEF_W_DEF,
    parameter int COEF_FRAC = rcc_pkg::COEF_FRAC_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] i_ref,
    input  logic signed [DATA_W-1:0] i_meas,
    input  logic signed [COEF_W-1:0] k1_coef,
    input  logic signed [COEF_W-1:0] k2_coef,
    input  logic signed [COEF_W-1:0] k3_coef,
    input  logic signed [COEF_W-1:0] res_coef,
    input  logic signed [DATA_W-1:0] u_min,
    input  logic signed [DATA_W-1:0] u_max,
    output logic signed [DATA_W-1:0] u_cmd,
    output logic                     u_valid
);
    localparam int ERR_W  = DATA_W + 1;
    localparam int PROD_W = ERR_W + COEF_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam int NM     = rcc_pkg::N_MUL;
    localparam int NS     = rcc_pkg::N_SAT;

    logic                     st_v;
    logic signed [DATA_W-1:0] st_ref, st_meas, st_umin, st_umax;
    logic signed [COEF_W-1:0] st_k1, st_k2, st_k3, st_res;
    logic signed [DATA_W-1:0] s1, s2;
    logic                     upd;
    logic signed [ERR_W-1:0]  err;

    logic signed [ERR_W-1:0]  mul_a [NM];
    logic signed [COEF_W-1:0] mul_c [NM];
    logic signed [PROD_W-1:0] mul_p [NM];
    logic signed [SUM_W-1:0]  sat_i [NS];
    logic signed [DATA_W-1:0] sat_o [NS];
    logic signed [DATA_W-1:0] u_lim;

    // Capture stage: sample and the coefficient set travel together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v    <= 1'b0;
            st_ref  <= '0;
            st_meas <= '0;
            st_umin <= '0;
            st_umax <= '0;
            st_k1   <= '0;
            st_k2   <= '0;
            st_k3   <= '0;
            st_res  <= '0;
        end else begin
            st_v <= smp_valid && !clr;
            if (smp_valid) begin
                st_ref  <= i_ref;
                st_meas <= i_meas;
                st_umin <= u_min;
                st_umax <= u_max;
                st_k1   <= k1_coef;
                st_k2   <= k2_coef;
                st_k3   <= k3_coef;
                st_res  <= res_coef;
            end
        end
    end

    assign upd = st_v && !clr;

    // Tracking error, one bit wider so it cannot overflow.
    always_comb err = ERR_W'(st_ref) - ERR_W'(st_meas);

    // Operand routing for the four products.
    always_comb begin
        mul_a[0] = err;              mul_c[0] = st_k1;
        mul_a[1] = err;              mul_c[1] = st_k2;
        mul_a[2] = ERR_W'(st_meas);  mul_c[2] = st_k3;
        mul_a[3] = ERR_W'(s2);       mul_c[3] = st_res;
    end

    for (genvar g = 0; g < NM; g++) begin : g_mul
        rcc_mul #(.AW(ERR_W), .CW(COEF_W), .CF(COEF_FRAC)) u_mul (
            .a(mul_a[g]), .c(mul_c[g]), .p(mul_p[g])
        );
    end

    // Wide sums for the command and the two state updates.
    always_comb begin
        sat_i[0] = SUM_W'(s2) - SUM_W'(mul_p[2]);
        sat_i[1] = -SUM_W'(s2) - SUM_W'(mul_p[0]);
        sat_i[2] = SUM_W'(s1) + SUM_W'(mul_p[3]) - SUM_W'(mul_p[1]);
    end

    for (genvar g = 0; g < NS; g++) begin : g_sat
        rcc_sat #(.IW(SUM_W), .OW(DATA_W)) u_sat (
            .din(sat_i[g]), .dout(sat_o[g])
        );
    end

    rcc_clamp #(.W(DATA_W)) u_clamp (
        .din(sat_o[0]), .lo(st_umin), .hi(st_umax), .dout(u_lim)
    );

    rcc_state #(.W(DATA_W)) u_state (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd),
        .nxt1(sat_o[1]), .nxt2(sat_o[2]), .s1(s1), .s2(s2)
    );

    // Output register: command and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_cmd   <= '0;
            u_valid <= 1'b0;
        end else begin
            u_valid <= upd;
            if (upd) u_cmd <= u_lim;
        end
    end

    // R2: every pulse traces back to a strobe two edges earlier, uncleared.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        u_valid |-> $past(smp_valid, 2) && !$past(clr, 2) && !$past(clr));

    // R8: a clear suppresses the next pulse.
    p_clr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !u_valid);

    // R7: with ordered limits, the command lies inside them.
    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && ($past(st_umin) <= $past(st_umax))) |->
            (u_cmd >= $past(st_umin)) && (u_cmd <= $past(st_umax)));
endmodule

// File: tb/resonant_current_ctrl_tb.sv
// Scoreboard bench: a driver task predicts each command and queues it with
// its arrival cycle; a monitor pops and compares on every output pulse.
module resonant_current_ctrl_tb;
    localparam int DW = 16;
    localparam int CW = 18;
    localparam int CF = 14;
    localparam longint DMAX = (64'sd1 <<< (DW-1)) - 1;
    localparam longint DMIN = -(64'sd1 <<< (DW-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [DW-1:0] i_ref = '0, i_meas = '0, u_min = '0, u_max = '0;
    logic signed [CW-1:0] k1_coef = '0, k2_coef = '0, k3_coef = '0, res_coef = '0;
    logic signed [DW-1:0] u_cmd;
    logic u_valid;

    always #2.5 clk = ~clk;

    resonant_current_ctrl #(.DATA_W(DW), .COEF_W(CW), .COEF_FRAC(CF)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
        .i_ref(i_ref), .i_meas(i_meas), .k1_coef(k1_coef), .k2_coef(k2_coef),
        .k3_coef(k3_coef), .res_coef(res_coef), .u_min(u_min), .u_max(u_max),
        .u_cmd(u_cmd), .u_valid(u_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    int n_pulse = 0;
    longint m1 = 0, m2 = 0;                 // model states
    longint mk1, mk2, mk3, mres, mlo, mhi;  // model coefficients
    longint q_val[$];
    longint q_cyc[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > DMAX) return DMAX;
        if (v < DMIN) return DMIN;
        return v;
    endfunction

    function automatic longint mulf(input longint a, input longint c);
        return (a * c) >>> CF;
    endfunction

    task automatic set_coefs(input longint a, input longint b, input longint c3,
                             input longint r, input longint lo, input longint hi);
        mk1 = a; mk2 = b; mk3 = c3; mres = r; mlo = lo; mhi = hi;
        k1_coef = CW'(a); k2_coef = CW'(b); k3_coef = CW'(c3); res_coef = CW'(r);
        u_min = DW'(lo); u_max = DW'(hi);
    endtask

    // Driver: predict, queue, then strobe one cycle (called at a negedge).
    task automatic send(input longint r, input longint x);
        longint e, u, n1, n2;
        e  = r - x;
        u  = sat(m2 - mulf(mk3, x));
        if (u > mhi) u = mhi;
        if (u < mlo) u = mlo;
        n1 = sat(-m2 - mulf(mk1, e));
        n2 = sat(m1 + mulf(mres, m2) - mulf(mk2, e));
        m1 = n1; m2 = n2;
        q_val.push_back(u);
        q_cyc.push_back(cyc + 2);
        i_ref = DW'(r); i_meas = DW'(x); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Monitor: compare each pulse with the head of the scoreboard (R2, R3-R7).
    always @(negedge clk) begin
        if (rst_n && u_valid) begin
            n_pulse++;
            if (q_val.size() == 0) begin
                check(1'b0, "R2/R8 unexpected u_valid", 1, 0);
            end else begin
                longint ev, ec;
                ev = q_val.pop_front();
                ec = q_cyc.pop_front();
                check(cyc == ec, "R2 pulse cycle", cyc, ec);
                check(longint'(u_cmd) == ev, "R3-R7 command value", longint'(u_cmd), ev);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam longint K1 = -13894;   // -0.8480
    localparam longint K2 = 14211;    //  0.8674
    localparam longint K3 = -29812;   // -1.8196
    localparam longint RC = 30792;    //  2*cos(2*pi*60/1080)

    initial begin
        int p0;
        set_coefs(K1, K2, K3, RC, DMIN, DMAX);
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check(u_cmd == '0, "R1 u_cmd in reset", longint'(u_cmd), 0);
        check(u_valid == 1'b0, "R1 u_valid in reset", u_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(u_cmd == '0 && u_valid == 1'b0, "R1 after release", longint'(u_cmd), 0);

        // R1/R3: first sample starts from zero states
        send(0, 1000);
        send(500, 400);
        repeat (3) @(negedge clk);

        // R4 R5: sinusoid tracked sample by sample, spaced then back-to-back (R2)
        for (int k = 0; k < 36; k++) begin
            longint r;
            r = longint'($rtoi(20000.0 * $sin(6.283185307 * k / 18.0)));
            send(r, (r * 7) / 8 + 50);
            if (k < 18) @(negedge clk);
        end
        repeat (3) @(negedge clk);

        // R9: change coefficients right after the strobe; sample keeps the old set
        send(3000, -2000);
        set_coefs(2 * K1, K2 / 2, -K3, RC, DMIN, DMAX);
        send(-1500, 1200);
        repeat (3) @(negedge clk);
        set_coefs(K1, K2, K3, RC, DMIN, DMAX);

        // R7: tight limits, then inverted limits (lower wins)
        set_coefs(K1, K2, K3, RC, -1000, 1000);
        send(8000, -9000);
        send(-8000, 9000);
        send(100, 90);
        set_coefs(K1, K2, K3, RC, 200, -200);
        send(0, 0);
        send(-5000, 5000);
        repeat (3) @(negedge clk);

        // R6: oversized gains push states and command into saturation
        set_coefs(131000, -131000, 131000, RC, DMIN, DMAX);
        send(32767, -32768);
        send(32767, -32768);
        set_coefs(K1, K2, K3, RC, DMIN, DMAX);
        send(0, 0);
        send(0, 0);
        send(10, -10);
        repeat (3) @(negedge clk);

        // R8: clear while idle, then next sample starts from zero states
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        m1 = 0; m2 = 0;
        send(0, 0);
        check(1'b1, "R8 clear-idle sample queued", 0, 0);
        repeat (3) @(negedge clk);
        send(4000, 1000);
        repeat (3) @(negedge clk);

        // R8: strobe then clear one cycle later -> no pulse, states zeroed
        p0 = n_pulse;
        i_ref = DW'(7000); i_meas = DW'(-7000); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m1 = 0; m2 = 0;
        repeat (4) @(negedge clk);
        check(n_pulse == p0, "R8 cancelled sample pulses", n_pulse - p0, 0);
        send(0, 2000);
        send(1000, 0);
        repeat (4) @(negedge clk);

        check(q_val.size() == 0, "R2 all results returned", q_val.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule